// File: doc/BRIEF.md
# Paced Pulse Update Scheduler

A compute engine produces all of its pulse-level updates for two pulse outputs, V and W, in one burst at the start of each code pass. This block takes those updates, holds them in a small queue, and releases them one at a time onto the two output pins. The releases are evenly spaced, so the pulses are spread over one multiplexer frame instead of appearing all at once.

The spacing comes from an 8-bit interval value N. One step of N is four clock cycles. The first release comes 4×N cycles after the frame-start strobe, and each later release follows 4×N cycles after the one before. Every frame start empties the queue and restarts the timer, so updates not yet released are lost. These losses are counted. When N is zero the queue is bypassed and each update reaches the pins on the next clock. A global invert bit chooses whether the pins are active low (the default) or active high. Each output has a gated one-cycle interrupt strobe that fires when the output enters its active level.

Top module: `pulse_pacer`

## Requirements
- R1: After reset both pins are at their inactive level (1 when invert is 0), both interrupt strobes are 0, the overflow flag is 0 and the lost counter is 0.
- R2: With interval 0, a push is driven to the output levels at the next clock edge and is not queued. The sign bit is push_v for lane V and push_w for lane W, and a bit value of 1 means active.
- R3: With interval N>0, queued updates are released in push order. The first release is at the clock edge 4×N cycles after the edge that samples frame_start, and each later release is 4×N edges after the previous one.
- R4: A release slot that finds the queue empty leaves both output levels unchanged, and release slots keep occurring until the next frame start.
- R5: A pin is 0 for an active level and 1 for an inactive level when invert is 0. When invert is 1 this mapping is reversed. The invert bit acts on both pins at once and takes effect in the same cycle, without a clock edge.
- R6: irq_v or irq_w is high for exactly one cycle, in the cycle after the edge at which that lane's level becomes active, and only if its enable is 1. Toggling invert raises no strobe.
- R7: A paced push while eight entries are queued is dropped and sets the overflow flag. The flag stays set until lost_clr.
- R8: A frame start discards all queued entries and adds their number to the lost counter, which saturates at 255. lost_clr sets the counter to 0, and it wins over a simultaneous frame start. A push that arrives together with a frame start is kept as the first entry of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Multiplexer frame start strobe |
| push | input | 1 | Update strobe from the engine |
| push_v | input | 1 | V sign bit of the update (1 = active) |
| push_w | input | 1 | W sign bit of the update (1 = active) |
| interval | input | 8 | Release spacing in units of 4 clocks; 0 selects bypass |
| invert | input | 1 | 1 makes the pins active high |
| irq_en_v | input | 1 | Enable for the V interrupt strobe |
| irq_en_w | input | 1 | Enable for the W interrupt strobe |
| lost_clr | input | 1 | Clears the lost counter and the overflow flag |
| pulse_v | output | 1 | V pulse pin |
| pulse_w | output | 1 | W pulse pin |
| irq_v | output | 1 | V interrupt strobe |
| irq_w | output | 1 | W interrupt strobe |
| overflow | output | 1 | Sticky queue-overflow flag |
| lost_count | output | 8 | Saturating count of flushed updates |

## Verification
The assertions assume that the inputs change only between clock edges and that push and frame_start are single-cycle strobes. They also assume that interval changes only while no frame is in flight in which its old value matters. The release-spacing check also assumes that interval is at least 1 whenever release slots occur. The stimulus changes every input on the falling clock edge. It changes interval only between test phases, either before a fresh frame start or after a reset, so that every frame runs with one fixed spacing.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
   localparam int LANE_V    = 0;
   localparam int LANE_W    = 1;
   localparam int LANES     = 2;
   localparam int UNIT_LOG2 = 2;

   typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/pacer_fifo.sv
module pacer_fifo #(
   parameter int W     = 2,
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          dropped
);
   if ((1 << PW) != DEPTH) begin : g_depth_bad
      $error("pacer_fifo: DEPTH must be a power of two");
   end
   if (W < 1) begin : g_width_bad
      $error("pacer_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rp, wp;
   logic          full, do_push, do_pop, we;
   logic [PW-1:0] waddr;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dropped = push && full && !flush;
   assign dout    = mem[rp];
   assign we      = flush ? push : do_push;
   assign waddr   = flush ? '0 : wp;

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp    <= '0;
         wp    <= '0;
         count <= '0;
      end else if (flush) begin
         rp    <= '0;
         wp    <= push ? PW'(1) : '0;
         count <= push ? CW'(1) : '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   // R7
   fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));

   // R8
   fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !push) |=> empty);
endmodule

// File: rtl/pacer_timer.sv
module pacer_timer #(
   parameter int IVW       = 8,
   parameter int UNIT_LOG2 = 2,
   localparam int CW       = IVW + UNIT_LOG2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           restart,
   input  logic [IVW-1:0] interval,
   output logic           tick
);
   if (UNIT_LOG2 < 1) begin : g_unit_bad
      $error("pacer_timer: UNIT_LOG2 must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;
   logic          active;

   assign active = (interval != '0);
   assign limit  = {interval, {UNIT_LOG2{1'b0}}} - CW'(1);
   assign tick   = active && !restart && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (restart || !active)    cnt <= '0;
      else if (cnt >= limit)          cnt <= '0;
      else                            cnt <= cnt + 1'b1;
   end

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R3
   tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick);
endmodule

// File: rtl/pacer_lane.sv
module pacer_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic nxt,
   input  logic invert,
   input  logic irq_en,
   output logic pin,
   output logic irq
);
   logic lv, lv_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lv   <= 1'b0;
         lv_d <= 1'b0;
      end else begin
         lv_d <= lv;
         if (load) lv <= nxt;
      end
   end

   assign pin = invert ? lv : ~lv;
   assign irq = irq_en && lv && !lv_d;

   // R6
   irq_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pin == invert));

   // R6
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

// File: rtl/pulse_pacer.sv
module pulse_pacer #(
   parameter int IVW   = 8,
   parameter int DEPTH = 8,
   parameter int LOSTW = 8,
   localparam int LANES = pacer_pkg::LANES,
   localparam int PW    = $clog2(DEPTH),
   localparam int CW    = PW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             push,
   input  logic             push_v,
   input  logic             push_w,
   input  logic [IVW-1:0]   interval,
   input  logic             invert,
   input  logic             irq_en_v,
   input  logic             irq_en_w,
   input  logic             lost_clr,
   output logic             pulse_v,
   output logic             pulse_w,
   output logic             irq_v,
   output logic             irq_w,
   output logic             overflow,
   output logic [LOSTW-1:0] lost_count
);
   import pacer_pkg::*;

   if (LOSTW < CW) begin : g_lost_bad
      $error("pulse_pacer: LOSTW too narrow for DEPTH");
   end

   lane_vec_t     din, dout, irq_en, pins, irqs;
   logic          bypass, tick, q_push, q_empty, q_drop, release_now;
   logic [CW-1:0] q_count;
   logic [LOSTW:0] lost_sum;

   assign bypass        = (interval == '0);
   assign din[LANE_V]    = push_v;
   assign din[LANE_W]    = push_w;
   assign irq_en[LANE_V] = irq_en_v;
   assign irq_en[LANE_W] = irq_en_w;
   assign q_push         = push && !bypass;
   assign release_now    = tick && !q_empty;

   pacer_timer #(.IVW(IVW), .UNIT_LOG2(UNIT_LOG2)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(frame_start),
      .interval(interval), .tick(tick));

   pacer_fifo #(.W(LANES), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(frame_start), .push(q_push),
      .pop(tick), .din(din), .dout(dout), .count(q_count),
      .empty(q_empty), .dropped(q_drop));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pacer_lane u_lane (
         .clk(clk), .rst_n(rst_n),
         .load((bypass && push) || (!bypass && release_now)),
         .nxt(bypass ? din[i] : dout[i]),
         .invert(invert), .irq_en(irq_en[i]),
         .pin(pins[i]), .irq(irqs[i]));
   end

   assign pulse_v = pins[LANE_V];
   assign pulse_w = pins[LANE_W];
   assign irq_v   = irqs[LANE_V];
   assign irq_w   = irqs[LANE_W];

   assign lost_sum = {1'b0, lost_count} + (LOSTW+1)'(q_count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lost_count <= '0;
         overflow   <= 1'b0;
      end else if (lost_clr) begin
         lost_count <= '0;
         overflow   <= 1'b0;
      end else begin
         if (q_drop) overflow <= 1'b1;
         if (frame_start)
            lost_count <= lost_sum[LOSTW] ? '1 : lost_sum[LOSTW-1:0];
      end
   end

   // R2
   bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && bypass) |=> ((pulse_v ^ ~invert) == $past(push_v)
                           && (pulse_w ^ ~invert) == $past(push_w)));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !lost_clr) |=> overflow);

   // R8
   lost_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_count == '1 && !lost_clr) |=> (lost_count == '1));

   // R8
   lost_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lost_clr |=> (lost_count == '0 && !overflow));
endmodule

// File: tb/tb_pulse_pacer.sv
module tb_pulse_pacer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_start = 1'b0, push = 1'b0, push_v = 1'b0, push_w = 1'b0;
   logic [7:0] interval = 8'd0;
   logic       invert = 1'b0, irq_en_v = 1'b0, irq_en_w = 1'b0, lost_clr = 1'b0;
   logic       pulse_v, pulse_w, irq_v, irq_w, overflow;
   logic [7:0] lost_count;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // {invert, v, w, irq enable}
   localparam logic [3:0] BYP_VEC [6] = '{4'b0101, 4'b0111, 4'b0001,
                                           4'b1110, 4'b1011, 4'b0000};

   pulse_pacer dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .push(push),
      .push_v(push_v), .push_w(push_w), .interval(interval), .invert(invert),
      .irq_en_v(irq_en_v), .irq_en_w(irq_en_w), .lost_clr(lost_clr),
      .pulse_v(pulse_v), .pulse_w(pulse_w), .irq_v(irq_v), .irq_w(irq_w),
      .overflow(overflow), .lost_count(lost_count));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pins_are(input string tag, input bit ev, input bit ew);
      chk({pulse_v, pulse_w} == {ev, ew}, tag, {pulse_v, pulse_w}, {ev, ew});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic frame();
      frame_start = 1'b1;
      step(1);
      frame_start = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      bit mv, mw;
      @(negedge clk);
      do_reset();
      // R1 reset state
      pins_are("R1 pins", 1'b1, 1'b1);
      chk({irq_v, irq_w} == 2'b00, "R1 irq", {irq_v, irq_w}, 0);
      chk(overflow == 1'b0, "R1 overflow", overflow, 0);
      chk(lost_count == 8'd0, "R1 lost", lost_count, 0);

      // R2 bypass table, R5 polarity, R6 irq gating
      mv = 1'b0; mw = 1'b0;
      for (int i = 0; i < 6; i++) begin
         logic [3:0] vec;
         bit eiv, eiw;
         vec = BYP_VEC[i];
         invert = vec[3]; irq_en_v = vec[0]; irq_en_w = vec[0];
         push = 1'b1; push_v = vec[2]; push_w = vec[1];
         step(1);
         push = 1'b0;
         eiv = vec[0] && vec[2] && !mv;
         eiw = vec[0] && vec[1] && !mw;
         mv = vec[2]; mw = vec[1];
         pins_are("R2 R5 bypass pins", vec[3] ? mv : !mv, vec[3] ? mw : !mw);
         chk({irq_v, irq_w} == {eiv, eiw}, "R6 bypass irq", {irq_v, irq_w}, {eiv, eiw});
         step(1);
      end
      invert = 1'b0;

      // R3 paced ordering and spacing, N = 2 -> 8 cycles
      do_reset();
      irq_en_v = 1'b1; irq_en_w = 1'b1;
      interval = 8'd2;
      frame();
      push = 1'b1; push_v = 1'b1; push_w = 1'b0; step(1);
      push_v = 1'b0; push_w = 1'b1; step(1);
      push_v = 1'b1; push_w = 1'b1; step(1);
      push = 1'b0;
      step(4);
      pins_are("R3 before first slot", 1'b1, 1'b1);
      step(1);
      pins_are("R3 first slot", 1'b0, 1'b1);
      chk({irq_v, irq_w} == 2'b10, "R6 first slot irq", {irq_v, irq_w}, 2);
      step(1);
      chk({irq_v, irq_w} == 2'b00, "R6 strobe one cycle", {irq_v, irq_w}, 0);
      step(6);
      pins_are("R3 before second slot", 1'b0, 1'b1);
      step(1);
      pins_are("R3 second slot", 1'b1, 1'b0);
      chk({irq_v, irq_w} == 2'b01, "R6 second slot irq", {irq_v, irq_w}, 1);
      step(8);
      pins_are("R3 third slot", 1'b0, 1'b0);
      chk({irq_v, irq_w} == 2'b10, "R6 third slot irq", {irq_v, irq_w}, 2);
      step(8);
      pins_are("R4 empty slot holds", 1'b0, 1'b0);
      step(16);
      pins_are("R4 later empty slots hold", 1'b0, 1'b0);

      // R5 invert is combinational and raises no strobe
      invert = 1'b1;
      #1;
      pins_are("R5 invert immediate", 1'b1, 1'b1);
      step(1);
      chk({irq_v, irq_w} == 2'b00, "R6 invert no irq", {irq_v, irq_w}, 0);
      invert = 1'b0;

      // R8 loss on flush, N = 10 -> 40 cycles
      do_reset();
      interval = 8'd10;
      frame();
      push = 1'b1; push_v = 1'b0; push_w = 1'b0;
      step(5);
      push = 1'b0;
      step(40);
      chk(lost_count == 8'd0, "R8 no loss before flush", lost_count, 0);
      frame();
      chk(lost_count == 8'd4, "R8 four flushed", lost_count, 4);

      // R7 overflow, R8 push kept at frame start
      interval = 8'd100;
      frame_start = 1'b1; push = 1'b1;
      step(1);
      frame_start = 1'b0;
      step(9);
      push = 1'b0;
      chk(overflow == 1'b1, "R7 overflow set", overflow, 1);
      frame();
      chk(lost_count == 8'd12, "R8 R7 eight held", lost_count, 12);
      chk(overflow == 1'b1, "R7 overflow sticky", overflow, 1);

      // R8 saturation
      for (int f = 0; f < 31; f++) begin
         push = 1'b1;
         step(10);
         push = 1'b0;
         frame();
      end
      chk(lost_count == 8'd255, "R8 saturate", lost_count, 255);

      // R8 clear wins over frame start
      push = 1'b1; step(3); push = 1'b0;
      lost_clr = 1'b1; frame_start = 1'b1;
      step(1);
      lost_clr = 1'b0; frame_start = 1'b0;
      chk(lost_count == 8'd0, "R8 clear wins", lost_count, 0);
      chk(overflow == 1'b0, "R7 overflow cleared", overflow, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule